// File: doc/BRIEF.md
# Block-Atomic Bus Arbiter for Four DMA Channels

This block shares one memory bus among several DMA channels (four by default). Each channel raises its request line when it has a block of words ready to move. The arbiter answers with a one-hot grant. The winning channel keeps the bus until it pulses the common block-done line, so a block burst is never split. After a block the grant is always dropped for one cycle. A channel that has finished a block then waits out its own interval before it asks again, so arbitration happens once per block and not once per whole transfer.

A single runtime input selects the policy. With the input low, a fixed order applies and the lowest-numbered requester wins. With the input high, a rotating order applies: the search begins at the channel after the one most recently granted. The policy input is sampled only when the bus is idle. A change made while a block is in flight therefore takes effect at the next arbitration.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, the grant vector is all zero. The round-robin pointer resets so that channel 0 is searched first.
- R2: The grant vector is always one-hot or all zero.
- R3: When the bus is idle and no request is high, the grant stays all zero on the next cycle.
- R4: With `rr_mode` = 0 at an idle cycle with requests, the next-cycle grant goes to the lowest-indexed requesting channel (bit i of `grant` is channel i).
- R5: With `rr_mode` = 1 at an idle cycle with requests, the next-cycle grant goes to the first requesting channel found by searching upward from the channel after the last granted one, wrapping from the top channel to channel 0.
- R6: While a grant is held and `blk_done` is low, the grant is unchanged on the next cycle, whatever `req` and `rr_mode` do.
- R7: `blk_done` high while a grant is held makes the grant all zero on the next cycle.
- R8: `blk_done` high while the bus is idle has no effect. The grant follows R3, R4 or R5 as if the pulse were absent.
- R9: `rr_mode` is used only in the idle cycle in which arbitration happens. Its value during a held block does not change that block's grant.
- R10: A new grant is only ever given to a channel whose request was high in the arbitration cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rr_mode | input | 1 | Policy: 0 fixed order, 1 rotating order |
| req | input | NUM_CH | Per-channel block request |
| blk_done | input | 1 | Pulse from the granted channel when its block ends |
| grant | output | NUM_CH | One-hot bus grant, all zero when idle |

## Verification
Every result appears exactly one clock edge after the inputs that cause it. An idle cycle with requests gives a grant on the next cycle. A `blk_done` gives an all-zero grant on the next cycle. A held grant is visible again on the next cycle. The bench drives inputs on the falling edge and steps a reference model once for each rising edge. It compares `grant` on the following falling edge, so each comparison lands on the one cycle where that result is due.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic {
        POL_FIXED = 1'b0,
        POL_ROUND = 1'b1
    } arb_policy_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } arb_state_e;

    // Wrap an index sum back into the channel range.
    function automatic int wrap_idx(input int sum, input int num_ch);
        return (sum >= num_ch) ? sum - num_ch : sum;
    endfunction

endpackage

// File: rtl/arb_fixed_pri.sv
module arb_fixed_pri #(
    parameter int NUM_CH = 4,
    localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] req,
    output logic              found,
    output logic [IW-1:0]     idx
);
    // Descending scan: the last hit written is the lowest index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/arb_round_robin.sv
module arb_round_robin #(
    parameter int NUM_CH = 4,
    localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [IW-1:0]     last_idx,
    output logic              found,
    output logic [IW-1:0]     idx
);
    import dma_arb_pkg::*;

    // Offsets scanned from farthest to nearest, so the nearest hit after
    // last_idx is what remains.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = NUM_CH; k >= 1; k--) begin
            int cand;
            cand = wrap_idx(int'(last_idx) + k, NUM_CH);
            if (req[cand]) begin
                found = 1'b1;
                idx   = IW'(cand);
            end
        end
    end
endmodule

// File: rtl/arb_grant_ctrl.sv
module arb_grant_ctrl #(
    parameter int NUM_CH = 4,
    localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rr_mode,
    input  logic              blk_done,
    input  logic              fx_found,
    input  logic [IW-1:0]     fx_idx,
    input  logic              rr_found,
    input  logic [IW-1:0]     rr_idx,
    output logic [IW-1:0]     last_idx,
    output logic [NUM_CH-1:0] grant
);
    import dma_arb_pkg::*;

    typedef struct packed {
        arb_state_e    state;
        logic [IW-1:0] owner;
        logic [IW-1:0] last;
    } ctrl_t;

    ctrl_t       cur;
    arb_policy_e pol;
    logic        pick_found;
    logic [IW-1:0] pick_idx;

    // The policy is looked at only here, and this result is consumed
    // only in the idle state.
    always_comb begin
        pol        = arb_policy_e'(rr_mode);
        pick_found = (pol == POL_ROUND) ? rr_found : fx_found;
        pick_idx   = (pol == POL_ROUND) ? rr_idx   : fx_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.state <= ST_IDLE;
            cur.owner <= '0;
            cur.last  <= IW'(NUM_CH - 1);
        end else begin
            unique case (cur.state)
                ST_IDLE: begin
                    if (pick_found) begin
                        cur.state <= ST_HELD;
                        cur.owner <= pick_idx;
                        cur.last  <= pick_idx;
                    end
                end
                ST_HELD: begin
                    if (blk_done) cur.state <= ST_IDLE;
                end
                default: cur.state <= ST_IDLE;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_grant
            assign grant[g] = (cur.state == ST_HELD) && (cur.owner == IW'(g));
        end
    endgenerate

    assign last_idx = cur.last;
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rr_mode,
    input  logic [NUM_CH-1:0] req,
    input  logic              blk_done,
    output logic [NUM_CH-1:0] grant
);
    localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic          fx_found, rr_found;
    logic [IW-1:0] fx_idx, rr_idx, last_idx;

    arb_fixed_pri #(.NUM_CH(NUM_CH)) u_fixed (
        .req   (req),
        .found (fx_found),
        .idx   (fx_idx)
    );

    arb_round_robin #(.NUM_CH(NUM_CH)) u_rr (
        .req      (req),
        .last_idx (last_idx),
        .found    (rr_found),
        .idx      (rr_idx)
    );

    arb_grant_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rr_mode  (rr_mode),
        .blk_done (blk_done),
        .fx_found (fx_found),
        .fx_idx   (fx_idx),
        .rr_found (rr_found),
        .rr_idx   (rr_idx),
        .last_idx (last_idx),
        .grant    (grant)
    );
endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rr_mode,
    input logic [NUM_CH-1:0] req,
    input logic              blk_done,
    input logic [NUM_CH-1:0] grant
);
    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: grant is clear on the cycle after reset was high
    always @(posedge clk) begin
        if (rst_d) a_r1_reset_clear: assert (grant == '0);
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r3_idle_stays: assert property (@(posedge clk) disable iff (rst)
        (grant == '0 && req == '0) |=> grant == '0);

    a_r4_fixed_lowest: assert property (@(posedge clk) disable iff (rst)
        (grant == '0 && req != '0 && !rr_mode)
        |=> grant == ($past(req) & (~$past(req) + 1'b1)));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && !blk_done) |=> grant == $past(grant));

    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && blk_done) |=> grant == '0);

    a_r10_to_requester: assert property (@(posedge clk) disable iff (rst)
        (grant == '0 && req != '0) |=> (grant & $past(req)) != '0);
endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rr_mode  (rr_mode),
    .req      (req),
    .blk_done (blk_done),
    .grant    (grant)
);

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rr_mode = 1'b0;
    logic [N-1:0] req = '0;
    logic         blk_done = 1'b0;
    logic [N-1:0] grant;

    int n_chk = 0;
    int n_err = 0;
    logic finished = 1'b0;

    logic [N-1:0] m_grant = '0;
    int           m_last  = N - 1;

    always #5 clk = ~clk;

    dma_bus_arbiter #(.NUM_CH(N)) u_dut (
        .clk(clk), .rst(rst), .rr_mode(rr_mode),
        .req(req), .blk_done(blk_done), .grant(grant)
    );

    function automatic int pick_fixed(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    function automatic int pick_rr(input logic [N-1:0] r, input int last);
        for (int k = 1; k <= N; k++) begin
            int c = (last + k) % N;
            if (r[c]) return c;
        end
        return -1;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive inputs on the falling edge, step the model for the rising
    // edge, then compare on the next falling edge.
    task automatic cyc(input logic [N-1:0] r, input logic d, input logic m,
                       input string tag);
        logic [N-1:0] prev_g;
        logic [N-1:0] prev_r;
        req = r; blk_done = d; rr_mode = m;
        prev_g = m_grant;
        prev_r = r;
        if (m_grant != '0) begin
            if (d) m_grant = '0;
        end else if (r != '0) begin
            int p = m ? pick_rr(r, m_last) : pick_fixed(r);
            m_grant = N'(1) << p;
            m_last  = p;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, grant, m_grant);
        check("R2", N'($onehot0(grant)), N'(1));
        if (prev_g == '0 && prev_r != '0)
            check("R10", N'((grant & prev_r) != '0), N'(1));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        check("R1", grant, '0);
        @(negedge clk);
        rst = 1'b0;
        check("R1", grant, '0);

        cyc(4'b1111, 0, 0, "R4");       // fixed: ch0
        cyc(4'b0000, 0, 1, "R6");       // req drop + mode flip: hold (R9)
        cyc(4'b0000, 1, 1, "R7");       // release
        cyc(4'b0000, 1, 1, "R8");       // done while idle: no effect
        cyc(4'b1111, 0, 1, "R5");       // rr after ch0: ch1
        cyc(4'b1111, 1, 0, "R7");
        cyc(4'b1001, 0, 1, "R5");       // rr after ch1: ch3
        cyc(4'b1001, 1, 1, "R7");
        cyc(4'b1001, 1, 1, "R5");       // wrap to ch0, done ignored (R8)
        cyc(4'b1110, 0, 0, "R9");       // mode low mid-block: hold ch0
        cyc(4'b1110, 1, 0, "R7");
        cyc(4'b1010, 0, 0, "R4");       // fixed: ch1
        cyc(4'b0000, 1, 0, "R7");
        cyc(4'b0000, 0, 0, "R3");

        for (int i = 0; i < 2000; i++) begin
            logic [N-1:0] r = N'($urandom);
            logic d = ($urandom % 3) == 0;
            logic m = (($urandom % 20) == 0) ? ~rr_mode : rr_mode;
            string tag;
            if (m_grant != '0) tag = d ? "R7" : "R6";
            else if (r == '0) tag = d ? "R8" : "R3";
            else tag = m ? "R5" : "R4";
            cyc(r, d, m, tag);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule